// File: doc/BRIEF.md
# Page Write Collector and Programming Timer

This block sits behind the serial slave engine of a byte-addressed non-volatile memory. The engine loads the starting word address and then hands over data bytes one at a time. The block stores each byte in a page-sized holding buffer and moves a shared address pointer after every byte. The pointer moves only within the current page, so the page-select bits never change during a transfer.

When the engine signals Stop, the block starts one self-timed programming cycle, provided at least one byte has been collected and write protection is off. Busy is held for a fixed number of system clocks. In the final busy cycle the block issues a single page-wide write to the array. That write carries the page number, all buffered bytes and a per-byte mask, so bytes that were not written keep their old contents. While busy, the block ignores every input strobe. Afterwards the pointer holds the address that follows the last byte written, wrapped within the page, ready for a current-address read.

Top module: `page_commit_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy_o` and `mem_we_o` are low and `addr_o` is zero.
- R2: A `load_i` accepted while idle sets `addr_o` to `start_addr_i` on the next cycle and empties the buffer. A byte strobe accepted while idle (with `load_i` and `stop_i` low) stores the byte at offset `addr_o[5:0]`. It then increments `addr_o[5:0]` by one and leaves `addr_o[13:6]` unchanged.
- R3: Stepping past offset 63 wraps to offset 0 of the same page. A byte that lands on an offset already written in the same transfer replaces the earlier value.
- R4: A Stop accepted while idle, with at least one buffered byte and `wp_i` low, raises `busy_o` on the next cycle. `busy_o` then stays high for exactly PROG_CYCLES consecutive cycles.
- R5: Each programming cycle gives exactly one `mem_we_o` pulse, in its final busy cycle. `mem_page_o` is the page bits `addr_o[13:6]`. Bit k of `mem_mask_o` is 1 exactly when offset k was written in the transfer. Byte k of `mem_data_o` (bits 8k+7..8k) is the last value written to offset k. Unwritten offsets have mask bit 0.
- R6: A Stop with no byte accepted since the last address load starts no cycle: `busy_o` and `mem_we_o` stay low.
- R7: A Stop with `wp_i` high discards the buffer and starts no cycle. If `wp_i` is high in the final busy cycle, no `mem_we_o` pulse is issued, although busy still runs its full length.
- R8: While `busy_o` is high, `load_i`, `byte_we_i` and `stop_i` have no effect. `addr_o` is unchanged, the busy period is neither extended nor restarted, and the commit contents are unaffected.
- R9: After programming ends, `addr_o` holds the page of the transfer with offset (start offset + byte count) mod 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Strobe: load the starting word address |
| start_addr_i | input | 14 | Starting word address |
| byte_we_i | input | 1 | Strobe: one received data byte |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Strobe: Stop seen on the bus |
| wp_i | input | 1 | Write protect, active high |
| mem_we_o | output | 1 | Page-wide array write strobe |
| mem_page_o | output | 8 | Page number for the array write |
| mem_mask_o | output | 64 | Per-byte write enable for the page |
| mem_data_o | output | 512 | Page data, byte k at bits 8k+7..8k |
| busy_o | output | 1 | Programming cycle in progress |
| addr_o | output | 14 | Shared word address pointer |

## Verification
Some properties are checked on every cycle. These are the in-page pointer step and the address load, and the frozen pointer while busy. Also checked every cycle are the exact busy length, measured by a run counter, and the rule that a commit strobe lies only in the last busy cycle and never under write protect. A Stop with an empty buffer, or with protect high, is also checked to leave busy low. Only the bench scenarios can show what data a commit carries: the mask for partial, full and overflowing pages, the values that win after a wrap, and the page number. The same holds for the pointer left behind after wrap-around, and for the fact that strobes poked during busy do not change the committed contents.

// File: rtl/page_commit_pkg.sv
`timescale 1ns/1ps
// Shared types for the page commit unit.
// Assumes: a two-state controller is enough (idle or programming).
package page_commit_pkg;
    typedef enum logic {
        PC_IDLE = 1'b0,
        PC_PROG = 1'b1
    } pc_state_e;
endpackage

// File: rtl/pc_addr_ptr.sv
`timescale 1ns/1ps
// Shared word address pointer.
// A load replaces the whole address. A step increments only the low
// OFF_W bits, so the page bits above them stay fixed.
// Assumes: load_i and step_i are never both high (the top gives load priority).
module pc_addr_ptr #(
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_q;

    // Pointer register: load, in-page step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= load_addr_i;
        end else if (step_i) begin
            ptr_q <= {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + OFF_W'(1)};
        end
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/pc_page_buf.sv
`timescale 1ns/1ps
// Page holding buffer with a per-byte valid mask.
// Each slot keeps one byte and a valid bit. A clear empties all valid bits.
// The data storage has no reset; only the mask says what is meaningful.
// Assumes: clear_i and wr_i never hit the same slot in one cycle.
module pc_page_buf #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8,
    localparam int SLOTS = 1 << OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [OFF_W-1:0]        wr_off_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic                    clear_i,
    output logic [SLOTS*DATA_W-1:0] data_o,
    output logic [SLOTS-1:0]        mask_o
);
    logic [SLOTS-1:0][DATA_W-1:0] slot_d;
    logic [SLOTS-1:0]             slot_v;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic hit;
        assign hit = wr_i && (wr_off_i == OFF_W'(k));

        // Valid bit: cleared on a buffer clear, set on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[k] <= 1'b0;
            end else if (clear_i) begin
                slot_v[k] <= 1'b0;
            end else if (hit) begin
                slot_v[k] <= 1'b1;
            end
        end

        // Data byte: capture on a write; a later write replaces it.
        always_ff @(posedge clk) begin
            if (hit) begin
                slot_d[k] <= wr_data_i;
            end
        end
    end

    assign data_o = slot_d;
    assign mask_o = slot_v;
endmodule

// File: rtl/pc_prog_timer.sv
`timescale 1ns/1ps
// Self-timed programming cycle.
// A start pulse while idle runs busy for exactly PROG_CYCLES clocks.
// last_o marks the final busy cycle.
// Assumes: PROG_CYCLES >= 1; starts while busy are ignored.
module pc_prog_timer
    import page_commit_pkg::*;
#(
    parameter int PROG_CYCLES = 250000,
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);

    pc_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    // Controller state and elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PC_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                PC_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) state_q <= PC_PROG;
                end
                PC_PROG: begin
                    if (cnt_q == LAST_CNT) begin
                        state_q <= PC_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= PC_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == PC_PROG);
    assign last_o = busy_o && (cnt_q == LAST_CNT);
endmodule

// File: rtl/page_commit_unit.sv
`timescale 1ns/1ps
// Page write collector and programming controller (top).
// Collects bytes into a page buffer at the in-page pointer. On Stop it runs
// one timed programming cycle and issues a single page-wide masked write in
// the last busy cycle.
// Assumes: strobes are single-cycle pulses from the serial engine. All input
// strobes are ignored while busy. Load wins over a byte; Stop wins over a byte.
module page_commit_unit #(
    parameter int ADDR_W      = 14,
    parameter int OFF_W       = 6,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 250000,
    localparam int SLOTS  = 1 << OFF_W,
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [ADDR_W-1:0]       start_addr_i,
    input  logic                    byte_we_i,
    input  logic [DATA_W-1:0]       byte_i,
    input  logic                    stop_i,
    input  logic                    wp_i,
    output logic                    mem_we_o,
    output logic [PAGE_W-1:0]       mem_page_o,
    output logic [SLOTS-1:0]        mem_mask_o,
    output logic [SLOTS*DATA_W-1:0] mem_data_o,
    output logic                    busy_o,
    output logic [ADDR_W-1:0]       addr_o
);
    logic              busy;
    logic              last;
    logic              take_load;
    logic              take_stop;
    logic              take_byte;
    logic              start_prog;
    logic              drop_buf;
    logic              clear_buf;
    logic              any_valid;
    logic [ADDR_W-1:0] ptr;
    logic [SLOTS-1:0]  mask;

    // Input acceptance: nothing gets through while busy.
    assign take_load  = load_i && !busy;
    assign take_stop  = stop_i && !busy;
    assign take_byte  = byte_we_i && !busy && !load_i && !stop_i;

    // Stop handling: program only with data and no protection; else discard.
    assign any_valid  = |mask;
    assign start_prog = take_stop && any_valid && !wp_i;
    assign drop_buf   = take_stop && wp_i;
    assign clear_buf  = take_load || drop_buf || last;

    pc_addr_ptr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (take_load),
        .load_addr_i (start_addr_i),
        .step_i      (take_byte),
        .ptr_o       (ptr)
    );

    pc_page_buf #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (take_byte),
        .wr_off_i  (ptr[OFF_W-1:0]),
        .wr_data_i (byte_i),
        .clear_i   (clear_buf),
        .data_o    (mem_data_o),
        .mask_o    (mask)
    );

    pc_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_prog),
        .busy_o  (busy),
        .last_o  (last)
    );

    // Array write port: one page-wide strobe at the end, suppressed under protect.
    assign mem_we_o   = last && !wp_i;
    assign mem_page_o = ptr[ADDR_W-1:OFF_W];
    assign mem_mask_o = mask;
    assign busy_o     = busy;
    assign addr_o     = ptr;
endmodule

// File: rtl/page_commit_unit_chk.sv
`timescale 1ns/1ps
// Protocol checker for page_commit_unit, bound to every instance.
// A run counter measures busy length, so no deep $past is needed.
module page_commit_unit_chk #(
    parameter int ADDR_W      = 14,
    parameter int OFF_W       = 6,
    parameter int PROG_CYCLES = 250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              byte_we_i,
    input logic              stop_i,
    input logic              wp_i,
    input logic              mem_we_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              any_valid
);
    int unsigned run_q;

    // Busy run-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !mem_we_o && addr_o == '0));

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> addr_o == $past(start_addr_i));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we_i && !busy_o && !load_i && !stop_i) |=>
        (addr_o[ADDR_W-1:OFF_W] == $past(addr_o[ADDR_W-1:OFF_W]) &&
         addr_o[OFF_W-1:0] == OFF_W'($past(addr_o[OFF_W-1:0]) + 1)));

    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && any_valid && !wp_i) |=> busy_o);

    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> run_q == PROG_CYCLES);

    a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> run_q < PROG_CYCLES);

    a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    a_r5_we_last: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !busy_o);

    a_r6_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !any_valid) |=> !busy_o);

    a_r7_no_write_protected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !wp_i);

    a_r7_wp_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && wp_i) |=> !busy_o);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(addr_o));
endmodule

bind page_commit_unit page_commit_unit_chk #(
    .ADDR_W      (ADDR_W),
    .OFF_W       (OFF_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .byte_we_i    (byte_we_i),
    .stop_i       (stop_i),
    .wp_i         (wp_i),
    .mem_we_o     (mem_we_o),
    .busy_o       (busy_o),
    .addr_o       (addr_o),
    .any_valid    (any_valid)
);

// File: tb/page_commit_unit_bench.sv
`timescale 1ns/1ps
module page_commit_unit_bench;
    localparam int PROG = 16;

    typedef struct packed {
        logic [13:0] addr;
        logic [7:0]  n;
        logic [7:0]  seed;
        logic        wp;
    } vec_t;

    // Stimulus table: start address, byte count, first data value, protect at Stop.
    localparam vec_t VECS [6] = '{
        '{14'h0010, 8'd1,  8'h11, 1'b0},   // single byte
        '{14'h1FC0, 8'd64, 8'h40, 1'b0},   // full page
        '{14'h3FFE, 8'd5,  8'hA0, 1'b0},   // wrap in last page
        '{14'h0105, 8'd70, 8'h00, 1'b0},   // overflow overwrites
        '{14'h2000, 8'd3,  8'h77, 1'b1},   // protected at Stop
        '{14'h0ABC, 8'd0,  8'h00, 1'b0}    // Stop with no data
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [13:0]  start_addr_i = '0;
    logic         byte_we_i = 1'b0;
    logic [7:0]   byte_i = '0;
    logic         stop_i = 1'b0;
    logic         wp_i = 1'b0;
    logic         mem_we_o;
    logic [7:0]   mem_page_o;
    logic [63:0]  mem_mask_o;
    logic [511:0] mem_data_o;
    logic         busy_o;
    logic [13:0]  addr_o;

    int n_chk = 0;
    int n_err = 0;
    int busy_tot = 0;
    int we_tot = 0;
    logic [7:0]   cap_page;
    logic [63:0]  cap_mask;
    logic [511:0] cap_data;

    always #10 clk = ~clk;

    page_commit_unit #(.PROG_CYCLES(PROG)) u_page_commit_unit (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
        .byte_we_i(byte_we_i), .byte_i(byte_i), .stop_i(stop_i), .wp_i(wp_i),
        .mem_we_o(mem_we_o), .mem_page_o(mem_page_o), .mem_mask_o(mem_mask_o),
        .mem_data_o(mem_data_o), .busy_o(busy_o), .addr_o(addr_o)
    );

    // Monitor at the falling edge: count busy cycles and capture commits.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_tot++;
            if (mem_we_o) begin
                we_tot++;
                cap_page = mem_page_o;
                cap_mask = mem_mask_o;
                cap_data = mem_data_o;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // One transfer: load, n bytes, Stop, then wait out the cycle and check.
    task automatic xfer(input logic [13:0] a, input int n, input logic [7:0] seed,
                        input logic wp_stop, input logic wp_mid, input logic poke);
        logic [63:0] em;
        logic [7:0]  ed [64];
        logic [13:0] ea;
        int b0, w0;
        logic ok;
        em = '0;
        for (int k = 0; k < 64; k++) ed[k] = '0;
        for (int i = 0; i < n; i++) begin
            int off;
            off = (int'(a[5:0]) + i) % 64;
            ed[off] = seed + 8'(i);
            em[off] = 1'b1;
        end
        ea = {a[13:6], 6'(int'(a[5:0]) + n)};
        b0 = busy_tot; w0 = we_tot;
        load_i = 1'b1; start_addr_i = a; tick();
        load_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_we_i = 1'b1; byte_i = seed + 8'(i); tick();
        end
        byte_we_i = 1'b0; wp_i = wp_stop; stop_i = 1'b1; tick();
        stop_i = 1'b0; wp_i = 1'b0;
        tick(); tick();
        if (poke) begin
            load_i = 1'b1; start_addr_i = 14'h0AAA; byte_we_i = 1'b1;
            byte_i = 8'hEE; stop_i = 1'b1; tick();
            load_i = 1'b0; byte_we_i = 1'b0; stop_i = 1'b0;
        end
        if (wp_mid) wp_i = 1'b1;
        repeat (PROG + 4) tick();
        wp_i = 1'b0;
        if (n > 0 && !wp_stop) begin
            chk("R4 busy length", 64'(busy_tot - b0), 64'(PROG));
            chk(wp_mid ? "R7 no write under protect" : "R5 single write strobe",
                64'(we_tot - w0), wp_mid ? 64'd0 : 64'd1);
            if (!wp_mid) begin
                chk("R5 page", 64'(cap_page), 64'(a[13:6]));
                chk("R5 R3 mask", cap_mask, em);
                ok = 1'b1;
                for (int k = 0; k < 64; k++)
                    if (em[k] && cap_data[k*8 +: 8] !== ed[k]) ok = 1'b0;
                chk("R3 R5 data", 64'(ok), 64'd1);
            end
        end else begin
            chk(wp_stop ? "R7 busy after protected stop" : "R6 busy after empty stop",
                64'(busy_tot - b0), 64'd0);
            chk(wp_stop ? "R7 write strobe" : "R6 write strobe", 64'(we_tot - w0), 64'd0);
        end
        chk(poke ? "R8 pointer kept" : "R9 R2 pointer after transfer", 64'(addr_o), 64'(ea));
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int b0;
        repeat (3) tick();
        chk("R1 busy in reset", 64'(busy_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 64'(busy_o), 64'd0);
        chk("R1 write", 64'(mem_we_o), 64'd0);
        chk("R1 pointer", 64'(addr_o), 64'd0);
        tick();

        for (int v = 0; v < 6; v++)
            xfer(VECS[v].addr, int'(VECS[v].n), VECS[v].seed, VECS[v].wp, 1'b0, 1'b0);

        // R7: protect raised during the cycle blocks the commit.
        xfer(14'h0200, 4, 8'h30, 1'b0, 1'b1, 1'b0);
        // R8: strobes poked while busy change nothing.
        xfer(14'h0300, 2, 8'h50, 1'b0, 1'b0, 1'b1);
        chk("R8 commit mask", cap_mask, 64'h3);

        // R6: buffer empty after commit; lone Stop starts nothing.
        b0 = busy_tot;
        stop_i = 1'b1; tick(); stop_i = 1'b0;
        repeat (4) tick();
        chk("R6 stop after commit", 64'(busy_tot - b0), 64'd0);

        // R6/R2: a fresh load empties the buffer.
        b0 = busy_tot;
        load_i = 1'b1; start_addr_i = 14'h0400; tick();
        load_i = 1'b0; byte_we_i = 1'b1; byte_i = 8'h99; tick();
        byte_we_i = 1'b0; load_i = 1'b1; start_addr_i = 14'h0450; tick();
        load_i = 1'b0; stop_i = 1'b1; tick(); stop_i = 1'b0;
        repeat (4) tick();
        chk("R6 stop after reload", 64'(busy_tot - b0), 64'd0);
        chk("R2 reload pointer", 64'(addr_o), 64'h0450);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule